// File: doc/BRIEF.md
# Transactional Line Cache with Single-Cycle Commit and Abort

This block is a small, fully associative cache placed next to a core's ordinary data cache. It holds every memory word that a transaction reads or writes. The core sends it three kinds of request: a plain transactional load, a load that announces a later write, and a store. The first time a transaction touches a resident line, the cache keeps two copies of it. One copy holds the value as it was when the transaction began, and it survives an abort. The other copy holds the working value, and it survives a commit. A single commit or abort pulse retags or drops every copy in the array in the same cycle.

A miss is served over a simple request/response bus port that carries the fetch commands and the victim writebacks. Committing moves no data. Modified lines reach memory only when a later allocation evicts them. When no line can be given up for a new pair of copies, the cache reports an overflow and aborts the running transaction.

Top module: `txn_line_cache`

## Requirements
- R1: The array holds NUM_LINES lines (64 by default) of 8 bytes each. The line address is req_addr_i[ADDR_W-1:3], and any line address can occupy any line, so addresses that share their low bits can all be resident together.
- R2: Request codes on req_op_i are 0 for a load, 1 for a load-with-intent-to-write and 2 for a store. A miss issues one bus fetch: command 0 (transactional read) for a load, or command 1 (transactional read-for-ownership) for the other two. The bus address is the line address followed by three zero bits, and a load returns the fetched data.
- R3: When a transaction first touches a line tagged NORMAL, the line becomes the saved copy tagged XCOMMIT, and a second line tagged XABORT receives the working value. A store writes only this working copy and causes no bus traffic.
- R4: Further accesses to the same line in the same transaction hit the working copy without bus traffic. A load returns the latest value stored to that line.
- R5: A line is freed for allocation in this order of preference: EMPTY, then NORMAL, then XCOMMIT, taking the lowest index within a class. A line tagged XABORT is never chosen.
- R6: A chosen line whose state is DIRTY is first written back with bus command 2, carrying its own address and data. A clean chosen line is reused without any bus request.
- R7: After a commit pulse, every XCOMMIT line is EMPTY and every XABORT line is NORMAL. Loads then return the values stored by the transaction without bus traffic, and the commit itself issues no bus request.
- R8: After an abort pulse, every XABORT line is EMPTY and every XCOMMIT line is NORMAL. Loads then return the values from before the transaction without bus traffic.
- R9: Committed modified data is not written to memory at commit. It reaches memory only when its line is later evicted.
- R10: If no line can be freed for a needed allocation, the response carries resp_overflow_o = 1 and the transaction is aborted as in R8. A line already fetched for that request stays resident as NORMAL.
- R11: A bus request keeps its valid, command, address and data unchanged until bus_resp_valid_i is seen.
- R12: After reset every line is EMPTY, and no response and no bus request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle request pulse, accepted only while idle |
| req_op_i | input | 2 | 0 load, 1 load-with-intent-to-write, 2 store |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_wdata_i | input | 64 | Store data (whole line) |
| commit_i | input | 1 | Commit pulse, taken while idle with no request |
| abort_i | input | 1 | Abort pulse, takes priority over commit |
| resp_valid_o | output | 1 | One-cycle pulse that completes a request |
| resp_rdata_o | output | 64 | Load data, or the stored value for a store |
| resp_overflow_o | output | 1 | Request ended in overflow and the transaction aborted |
| bus_req_valid_o | output | 1 | Bus request pending |
| bus_req_cmd_o | output | 2 | 0 transactional read, 1 transactional read-for-ownership, 2 write |
| bus_req_addr_o | output | ADDR_W | Line-aligned bus address |
| bus_req_wdata_o | output | 64 | Writeback data |
| bus_resp_valid_i | input | 1 | Bus completion, carries fetch data |
| bus_resp_data_i | input | 64 | Fetched line data |

## Verification
The hardest case to reach is a fully packed array. Every line is either a working copy or a saved copy, and the request must then first take an XCOMMIT line for its fetch and then find nothing left for its pair. The bench gets there by opening a transaction and loading distinct addresses without committing, one more than half the line count and then one at a time past that. Each new address turns one more saved copy into a working copy, until the last fetch succeeds and the pair allocation overflows. The eviction path is reached the other way round: a committed dirty line is left as the lowest NORMAL entry, and load-and-commit rounds are repeated until it is the only line that can be given up.

// File: rtl/tcache_pkg.sv
package tcache_pkg;
  typedef enum logic [1:0] {CS_INVALID, CS_VALID, CS_DIRTY, CS_RESERVED} coh_e;
  typedef enum logic [1:0] {TX_EMPTY, TX_NORMAL, TX_XCOMMIT, TX_XABORT} txtag_e;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_LOADX = 2'd1, OP_STORE = 2'd2} op_e;
  typedef enum logic [1:0] {BUS_TREAD = 2'd0, BUS_TRFO = 2'd1, BUS_WRITE = 2'd2} bus_cmd_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WB, ST_FILL} fsm_e;
endpackage

// File: rtl/tc_match.sv
module tc_match
  import tcache_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int TAG_W     = 29,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LINES-1:0][1:0]        tx_i,
  input  logic [NUM_LINES-1:0][TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]                 look_tag_i,
  output logic                             xab_hit_o,
  output logic [IDX_W-1:0]                 xab_idx_o,
  output logic                             norm_hit_o,
  output logic [IDX_W-1:0]                 norm_idx_o
);
  logic [NUM_LINES-1:0] xab_vec, norm_vec;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
    logic same;
    assign same        = (tag_i[g] == look_tag_i);
    assign xab_vec[g]  = same && (tx_i[g] == TX_XABORT);
    assign norm_vec[g] = same && (tx_i[g] == TX_NORMAL);
  end

  always_comb begin
    xab_idx_o  = '0;
    norm_idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (xab_vec[i])  xab_idx_o  = IDX_W'(i);
      if (norm_vec[i]) norm_idx_o = IDX_W'(i);
    end
  end

  assign xab_hit_o  = |xab_vec;
  assign norm_hit_o = |norm_vec;

  // a line address is never held twice as a working copy or as a plain line
  p_single_xab_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(xab_vec));
  p_single_norm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(norm_vec));
endmodule

// File: rtl/tc_victim.sv
module tc_victim
  import tcache_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_LINES-1:0][1:0] tx_i,
  input  logic [NUM_LINES-1:0]      excl_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [NUM_LINES-1:0] c_empty, c_norm, c_xcom;
  logic [IDX_W-1:0] i_empty, i_norm, i_xcom;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cls
    assign c_empty[g] = !excl_i[g] && (tx_i[g] == TX_EMPTY);
    assign c_norm[g]  = !excl_i[g] && (tx_i[g] == TX_NORMAL);
    assign c_xcom[g]  = !excl_i[g] && (tx_i[g] == TX_XCOMMIT);
  end

  always_comb begin
    i_empty = '0;
    i_norm  = '0;
    i_xcom  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (c_empty[i]) i_empty = IDX_W'(i);
      if (c_norm[i])  i_norm  = IDX_W'(i);
      if (c_xcom[i])  i_xcom  = IDX_W'(i);
    end
    found_o = 1'b1;
    if (|c_empty)      idx_o = i_empty;
    else if (|c_norm)  idx_o = i_norm;
    else if (|c_xcom)  idx_o = i_xcom;
    else begin
      idx_o   = '0;
      found_o = 1'b0;
    end
  end

  p_never_xabort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (tx_i[idx_o] != TX_XABORT) && !excl_i[idx_o]);
  p_empty_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && (tx_i[idx_o] != TX_EMPTY)) |-> (c_empty == '0));
endmodule

// File: rtl/txn_line_cache.sv
module txn_line_cache
  import tcache_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LINE_W-1:0] req_wdata_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              resp_valid_o,
  output logic [LINE_W-1:0] resp_rdata_o,
  output logic              resp_overflow_o,
  output logic              bus_req_valid_o,
  output logic [1:0]        bus_req_cmd_o,
  output logic [ADDR_W-1:0] bus_req_addr_o,
  output logic [LINE_W-1:0] bus_req_wdata_o,
  input  logic              bus_resp_valid_i,
  input  logic [LINE_W-1:0] bus_resp_data_i
);
  txtag_e            line_tx_q   [NUM_LINES];
  coh_e              line_coh_q  [NUM_LINES];
  logic [TAG_W-1:0]  line_tag_q  [NUM_LINES];
  logic [LINE_W-1:0] line_data_q [NUM_LINES];

  fsm_e              state_q;
  op_e               op_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] wdata_q;
  logic [IDX_W-1:0]  vic_q;

  logic [NUM_LINES-1:0][1:0]       tx_vec;
  logic [NUM_LINES-1:0][TAG_W-1:0] tag_vec;
  logic [NUM_LINES-1:0]            excl_vec, xc_vec, xa_vec;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      tx_vec[i]  = line_tx_q[i];
      tag_vec[i] = line_tag_q[i];
      xc_vec[i]  = (line_tx_q[i] == TX_XCOMMIT);
      xa_vec[i]  = (line_tx_q[i] == TX_XABORT);
    end
  end

  logic             xab_hit, norm_hit, vic_found;
  logic [IDX_W-1:0] xab_idx, norm_idx, vic_idx;

  tc_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_match (
    .clk_i, .rst_ni,
    .tx_i       (tx_vec),
    .tag_i      (tag_vec),
    .look_tag_i (tag_q),
    .xab_hit_o  (xab_hit),
    .xab_idx_o  (xab_idx),
    .norm_hit_o (norm_hit),
    .norm_idx_o (norm_idx)
  );

  // the plain line being split must not be reused for its own working copy
  always_comb begin
    excl_vec = '0;
    if (norm_hit) excl_vec[norm_idx] = 1'b1;
  end

  tc_victim #(.NUM_LINES(NUM_LINES)) u_victim (
    .clk_i, .rst_ni,
    .tx_i    (tx_vec),
    .excl_i  (excl_vec),
    .found_o (vic_found),
    .idx_o   (vic_idx)
  );

  logic vic_dirty, is_store, take_cmd;
  assign vic_dirty = (line_coh_q[vic_idx] == CS_DIRTY);
  assign is_store  = (op_q == OP_STORE);
  assign take_cmd  = (state_q == ST_IDLE) && !req_valid_i;

  assign bus_req_valid_o = (state_q == ST_WB) || (state_q == ST_FILL);
  assign bus_req_cmd_o   = (state_q == ST_WB) ? BUS_WRITE :
                           (op_q == OP_LOAD) ? BUS_TREAD : BUS_TRFO;
  assign bus_req_addr_o  = (state_q == ST_WB) ? {line_tag_q[vic_q], {OFF_W{1'b0}}}
                                              : {tag_q, {OFF_W{1'b0}}};
  assign bus_req_wdata_o = (state_q == ST_WB) ? line_data_q[vic_q] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_IDLE;
      op_q            <= OP_LOAD;
      tag_q           <= '0;
      wdata_q         <= '0;
      vic_q           <= '0;
      resp_valid_o    <= 1'b0;
      resp_rdata_o    <= '0;
      resp_overflow_o <= 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
        line_tx_q[i]   <= TX_EMPTY;
        line_coh_q[i]  <= CS_INVALID;
        line_tag_q[i]  <= '0;
        line_data_q[i] <= '0;
      end
    end else begin
      resp_valid_o    <= 1'b0;
      resp_overflow_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            op_q    <= (req_op_i == 2'd3) ? OP_LOAD : op_e'(req_op_i);
            tag_q   <= req_addr_i[ADDR_W-1:OFF_W];
            wdata_q <= req_wdata_i;
            state_q <= ST_LOOK;
          end else if (abort_i) begin
            for (int i = 0; i < NUM_LINES; i++) begin
              if (line_tx_q[i] == TX_XABORT) begin
                line_tx_q[i]  <= TX_EMPTY;
                line_coh_q[i] <= CS_INVALID;
              end else if (line_tx_q[i] == TX_XCOMMIT) begin
                line_tx_q[i] <= TX_NORMAL;
              end
            end
          end else if (commit_i) begin
            for (int i = 0; i < NUM_LINES; i++) begin
              if (line_tx_q[i] == TX_XCOMMIT) begin
                line_tx_q[i]  <= TX_EMPTY;
                line_coh_q[i] <= CS_INVALID;
              end else if (line_tx_q[i] == TX_XABORT) begin
                line_tx_q[i] <= TX_NORMAL;
              end
            end
          end
        end
        ST_LOOK: begin
          if (xab_hit) begin
            resp_valid_o <= 1'b1;
            resp_rdata_o <= is_store ? wdata_q : line_data_q[xab_idx];
            if (is_store) begin
              line_data_q[xab_idx] <= wdata_q;
              line_coh_q[xab_idx]  <= CS_DIRTY;
            end
            state_q <= ST_IDLE;
          end else if (!vic_found) begin
            // overflow: abort the running transaction
            for (int i = 0; i < NUM_LINES; i++) begin
              if (line_tx_q[i] == TX_XABORT) begin
                line_tx_q[i]  <= TX_EMPTY;
                line_coh_q[i] <= CS_INVALID;
              end else if (line_tx_q[i] == TX_XCOMMIT) begin
                line_tx_q[i] <= TX_NORMAL;
              end
            end
            resp_valid_o    <= 1'b1;
            resp_overflow_o <= 1'b1;
            resp_rdata_o    <= '0;
            state_q         <= ST_IDLE;
          end else if (vic_dirty) begin
            vic_q   <= vic_idx;
            state_q <= ST_WB;
          end else if (norm_hit) begin
            line_tx_q[norm_idx]  <= TX_XCOMMIT;
            line_tx_q[vic_idx]   <= TX_XABORT;
            line_tag_q[vic_idx]  <= tag_q;
            line_data_q[vic_idx] <= is_store ? wdata_q : line_data_q[norm_idx];
            line_coh_q[vic_idx]  <= is_store ? CS_DIRTY : line_coh_q[norm_idx];
            resp_valid_o         <= 1'b1;
            resp_rdata_o         <= is_store ? wdata_q : line_data_q[norm_idx];
            state_q              <= ST_IDLE;
          end else begin
            vic_q   <= vic_idx;
            state_q <= ST_FILL;
          end
        end
        ST_WB: begin
          if (bus_resp_valid_i) begin
            line_tx_q[vic_q]  <= TX_EMPTY;
            line_coh_q[vic_q] <= CS_INVALID;
            state_q           <= ST_LOOK;
          end
        end
        ST_FILL: begin
          if (bus_resp_valid_i) begin
            line_tx_q[vic_q]   <= TX_NORMAL;
            line_tag_q[vic_q]  <= tag_q;
            line_data_q[vic_q] <= bus_resp_data_i;
            line_coh_q[vic_q]  <= (op_q == OP_LOAD) ? CS_VALID : CS_RESERVED;
            state_q            <= ST_LOOK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_valid_o && !bus_resp_valid_i) |=>
      (bus_req_valid_o && $stable(bus_req_cmd_o) && $stable(bus_req_addr_o) && $stable(bus_req_wdata_o)));
  p_commit_sweep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_cmd && commit_i && !abort_i) |=> (xc_vec == '0) && (xa_vec == '0) && !bus_req_valid_o);
  p_abort_sweep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_cmd && abort_i) |=> (xc_vec == '0) && (xa_vec == '0));
  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_overflow_o |-> resp_valid_o && (xa_vec == '0) && (xc_vec == '0));
  p_pair_balance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(xc_vec) <= $countones(xa_vec));
  p_quiet_after_reset_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !resp_valid_o && !bus_req_valid_o);
endmodule

// File: tb/sim_txn_line_cache.sv
module sim_txn_line_cache;
  localparam int NL = 8;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'd0;
  logic [AW-1:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        commit_i = 1'b0, abort_i = 1'b0;
  logic        resp_valid_o, resp_overflow_o;
  logic [63:0] resp_rdata_o;
  logic        bus_req_valid_o;
  logic [1:0]  bus_req_cmd_o;
  logic [AW-1:0] bus_req_addr_o;
  logic [63:0] bus_req_wdata_o;
  logic        bus_resp_valid_i = 1'b0;
  logic [63:0] bus_resp_data_i = '0;

  always #2.5 clk = ~clk;

  txn_line_cache #(.NUM_LINES(NL), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_op_i, .req_addr_i, .req_wdata_i,
    .commit_i, .abort_i, .resp_valid_o, .resp_rdata_o, .resp_overflow_o,
    .bus_req_valid_o, .bus_req_cmd_o, .bus_req_addr_o, .bus_req_wdata_o,
    .bus_resp_valid_i, .bus_resp_data_i
  );

  int n_chk = 0, n_bad = 0;
  int n_rd = 0, n_rfo = 0, n_wr = 0, n_unstable = 0;
  logic [1:0]  last_cmd;
  logic [AW-1:0] last_addr;
  logic [63:0] last_wdata;
  logic [63:0] mem [256];

  function automatic logic [63:0] minit(int w);
    return {32'h1357_9BDF ^ w, ~32'(w)};
  endfunction

  function automatic logic [AW-1:0] wa(int w);
    return AW'(w) << 3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus responder: 3-cycle latency, checks the request stays put
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req_valid_o && rst_ni) begin
        logic [1:0] c; logic [AW-1:0] a; logic [63:0] d;
        c = bus_req_cmd_o; a = bus_req_addr_o; d = bus_req_wdata_o;
        repeat (3) begin
          @(negedge clk);
          if (!bus_req_valid_o || bus_req_cmd_o != c || bus_req_addr_o != a || bus_req_wdata_o != d)
            n_unstable++;
        end
        last_cmd = c; last_addr = a;
        if (c == 2'd2) begin
          n_wr++; last_wdata = d; mem[a[10:3]] = d;
        end else begin
          if (c == 2'd0) n_rd++; else n_rfo++;
          bus_resp_data_i = mem[a[10:3]];
        end
        bus_resp_valid_i = 1'b1;
        @(negedge clk);
        bus_resp_valid_i = 1'b0;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = minit(i);
    n_rd = 0; n_rfo = 0; n_wr = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_req(input logic [1:0] op, input int w, input logic [63:0] wd,
                        output logic [63:0] rd, output logic ovf);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = wa(w); req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0;
    rd = '0; ovf = 1'b0;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (resp_valid_o) begin
        rd = resp_rdata_o; ovf = resp_overflow_o;
        break;
      end
    end
  endtask

  task automatic pulse(input bit is_abort);
    @(negedge clk);
    if (is_abort) abort_i = 1'b1; else commit_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0; commit_i = 1'b0;
    chk(!bus_req_valid_o, is_abort ? "R8 abort bus idle" : "R7 commit bus idle",
        64'(bus_req_valid_o), 64'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!resp_valid_o, "R12 no response", 64'(resp_valid_o), 0);
    chk(!bus_req_valid_o, "R12 no bus request", 64'(bus_req_valid_o), 0);
  endtask

  task automatic t_fill();
    logic [63:0] rd; logic ovf;
    do_reset();
    do_req(2'd0, 5, 0, rd, ovf);
    chk(rd == minit(5), "R2 load fill data", rd, minit(5));
    chk(n_rd == 1 && last_cmd == 2'd0 && last_addr == wa(5), "R2 T_READ issued", 64'(last_addr), 64'(wa(5)));
    do_req(2'd1, 6, 0, rd, ovf);
    chk(n_rfo == 1 && last_cmd == 2'd1, "R2 load-excl uses T_RFO", 64'(last_cmd), 1);
    do_req(2'd2, 7, 64'hDEAD_BEEF_0000_0007, rd, ovf);
    chk(n_rfo == 2 && last_cmd == 2'd1 && last_addr == wa(7), "R2 store uses T_RFO", 64'(n_rfo), 2);
    do_req(2'd0, 7, 0, rd, ovf);
    chk(rd == 64'hDEAD_BEEF_0000_0007, "R4 load sees store", rd, 64'hDEAD_BEEF_0000_0007);
    do_req(2'd0, 5, 0, rd, ovf);
    chk(rd == minit(5) && n_rd == 1 && n_rfo == 2, "R4 repeat hit no bus", 64'(n_rd + n_rfo), 3);
    chk(n_wr == 0 && mem[7] == minit(7), "R3 store stays in cache", mem[7], minit(7));
  endtask

  task automatic t_assoc();
    logic [63:0] rd; logic ovf; bit ok;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      do_req(2'd0, 3 + 8 * k, 0, rd, ovf);
      pulse(1'b0);
    end
    ok = 1;
    for (int k = 0; k < 4; k++) begin
      do_req(2'd0, 3 + 8 * k, 0, rd, ovf);
      if (rd != minit(3 + 8 * k)) ok = 0;
    end
    chk(ok && n_rd == 4, "R1 aliasing lines all resident", 64'(n_rd), 4);
  endtask

  task automatic t_commit_abort();
    logic [63:0] rd; logic ovf;
    do_reset();
    do_req(2'd0, 9, 0, rd, ovf);
    pulse(1'b0);
    do_req(2'd2, 9, 64'h1111_2222_3333_4444, rd, ovf);
    chk(n_rd == 1 && n_rfo == 0 && n_wr == 0, "R3 store to NORMAL no bus", 64'(n_rd + n_rfo + n_wr), 1);
    pulse(1'b1);
    do_req(2'd0, 9, 0, rd, ovf);
    chk(rd == minit(9) && n_rd == 1, "R8 abort restores old value", rd, minit(9));
    pulse(1'b0);
    do_req(2'd2, 9, 64'h5555_6666_7777_8888, rd, ovf);
    pulse(1'b0);
    do_req(2'd0, 9, 0, rd, ovf);
    chk(rd == 64'h5555_6666_7777_8888 && n_rd == 1, "R7 commit keeps new value", rd, 64'h5555_6666_7777_8888);
    chk(n_wr == 0 && mem[9] == minit(9), "R9 commit writes no memory", mem[9], minit(9));
  endtask

  task automatic t_evict();
    logic [63:0] rd; logic ovf; bit ok;
    do_reset();
    do_req(2'd2, 16, 64'hABCD_0000_0000_0016, rd, ovf);
    pulse(1'b0);
    ok = 1;
    for (int k = 0; k < 6; k++) begin
      do_req(2'd0, 32 + k, 0, rd, ovf);
      if (rd != minit(32 + k)) ok = 0;
      pulse(1'b0);
    end
    chk(ok && n_wr == 0, "R9 no writeback before eviction", 64'(n_wr), 0);
    do_req(2'd0, 38, 0, rd, ovf);
    chk(rd == minit(38), "R5 load after eviction", rd, minit(38));
    chk(n_wr == 1 && last_addr == wa(16), "R6 dirty NORMAL victim written back", 64'(last_addr), 64'(wa(16)));
    chk(mem[16] == 64'hABCD_0000_0000_0016, "R9 committed data reaches memory", mem[16], 64'hABCD_0000_0000_0016);
  endtask

  task automatic t_overflow();
    logic [63:0] rd; logic ovf; bit ok;
    do_reset();
    ok = 1;
    for (int k = 0; k < 7; k++) begin
      do_req(2'd0, 48 + k, 0, rd, ovf);
      if (ovf || rd != minit(48 + k)) ok = 0;
    end
    chk(ok, "R5 XCOMMIT lines reused before overflow", 64'(ok), 1);
    chk(n_wr == 0, "R6 clean victims dropped silently", 64'(n_wr), 0);
    do_req(2'd0, 55, 0, rd, ovf);
    chk(ovf == 1'b1, "R10 overflow flagged", 64'(ovf), 1);
    chk(n_rd == 8, "R10 fetch before overflow", 64'(n_rd), 8);
    do_req(2'd0, 55, 0, rd, ovf);
    chk(!ovf && rd == minit(55) && n_rd == 8, "R10 fetched line kept NORMAL", rd, minit(55));
    do_req(2'd0, 49, 0, rd, ovf);
    chk(rd == minit(49) && n_rd == 9, "R10 aborted working copy dropped", 64'(n_rd), 9);
    chk(n_unstable == 0, "R11 bus request held", 64'(n_unstable), 0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_assoc();
    t_commit_abort();
    t_evict();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule